// File: doc/BRIEF.md
# Four-Terminal Arbitrated Shared Bus Network

This block links four input terminals to four output terminals over one shared bus. Each input terminal pushes single-word packets through a valid/ready handshake into its own small FIFO. In every cycle a round-robin arbiter looks at the four FIFO heads that hold a packet and grants exactly one of them. The granted packet is driven onto the bus, which is copied to every output lane. Only the output named by the packet's destination field raises its valid bit.

The control path is purely combinational. A transfer completes only when the addressed output is ready in the same cycle. In that cycle the winning FIFO pops its head, and the arbiter moves its priority so that the winner becomes the lowest-priority input. If the addressed output is not ready, nothing is popped and the priority is held. A packet that reaches an empty FIFO is offered on the bus in the next cycle.

A packet is one word of `PKT_W = 2*DEST_W + TAG_W + PAYLOAD_W` bits. From the most significant end it holds a source field (`DEST_W` bits), a destination field (`DEST_W` bits), an opaque tag (`TAG_W` bits) and the payload (`PAYLOAD_W` bits). With the defaults (four terminals, `TAG_W` = 4, `PAYLOAD_W` = 8) the word is 16 bits wide, the destination sits in bits [13:12] and the source sits in bits [15:14].

Top module: `shared_bus_net`

## Requirements
- R1: During and after reset all FIFOs are empty. This means `in_ready` is all ones and `out_valid` is all zeros. Input 0 holds the highest arbitration priority.
- R2: When a packet is on the bus, only `out_valid[d]` is high, where d is the destination field (bits [13:12] at the defaults). Output lane d carries the packet word unchanged.
- R3: A packet accepted by an empty FIFO, with no other traffic, appears on its output in the cycle after the input handshake.
- R4: At most one `out_valid` bit is high in any cycle, and at most one packet leaves the network per cycle.
- R5: With several FIFO heads waiting, the grant goes to the first waiting input found when searching upward from the priority pointer, wrapping from 3 to 0. After a completed transfer, the input just served becomes the lowest priority.
- R6: While the addressed output holds `out_ready` low, the granted packet stays in its FIFO and stays on the bus, and the priority does not move.
- R7: Each FIFO holds two packets. It accepts two back-to-back packets while nothing drains, and it then holds `in_ready` low.
- R8: Packets from one input leave in the order in which they were accepted.
- R9: The source and tag fields have no effect on routing. A packet whose source field differs from its real input still reaches the output named by its destination, with every bit unchanged.
- R10: When no FIFO holds a packet, all `out_valid` bits are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | NTERM | Per-input packet valid |
| in_ready | output | NTERM | Per-input FIFO has room |
| in_pkt | input | NTERM*PKT_W | Per-input packet words, lane i at bits [i*PKT_W +: PKT_W] |
| out_valid | output | NTERM | Per-output packet valid |
| out_ready | input | NTERM | Per-output sink ready |
| out_pkt | output | NTERM*PKT_W | Bus word copied to every output lane |

## Verification
The bench uses the default build: four terminals, two-entry FIFOs, an 8-bit payload and a 4-bit tag. At this size every pair of source input and destination output can be swept, each pair with a deliberate one-cycle stall on its target. The size also allows both FIFO slots of all four inputs to be filled together. The full eight-packet drain order can then be predicted from a priority pointer that the bench tracks on its own, including a pointer position left behind by the earlier sweep.

// File: rtl/busnet_pkg.sv
package busnet_pkg;

  // width of an index over n items, never below one bit
  function automatic int idx_bits(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // next index around a ring of n positions
  function automatic int wrap_inc(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // position reached by stepping off places from base on a ring of n
  function automatic int ring_pos(input int base, input int off, input int n);
    int s;
    s = base + off;
    return (s >= n) ? s - n : s;
  endfunction

endpackage

// File: rtl/busnet_fifo.sv
module busnet_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 2,
  localparam int AW   = busnet_pkg::idx_bits(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enq_vld,
  output logic         enq_rdy,
  input  logic [W-1:0] enq_data,
  output logic         deq_vld,
  input  logic         deq_rdy,
  output logic [W-1:0] deq_data
);

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] head_q, tail_q;
  logic [CW-1:0] count_q;
  logic          enq_fire, deq_fire;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return AW'(busnet_pkg::wrap_inc(int'(p), DEPTH));
  endfunction

  assign enq_rdy  = (count_q != CW'(DEPTH));
  assign deq_vld  = (count_q != '0);
  assign deq_data = store[head_q];
  assign enq_fire = enq_vld && enq_rdy;
  assign deq_fire = deq_vld && deq_rdy;

  always_ff @(posedge clk) begin
    if (enq_fire) store[tail_q] <= enq_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (enq_fire) tail_q <= ptr_next(tail_q);
      if (deq_fire) head_q <= ptr_next(head_q);
      case ({enq_fire, deq_fire})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  // R7: a lone enqueue grows occupancy by exactly one
  assert_fill_step_R7: assert property (@(posedge clk) disable iff (rst)
    (enq_fire && !deq_fire) |=> (count_q == $past(count_q) + CW'(1)));

  // R7: a full queue that is not drained refuses the next word
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    ((count_q == CW'(DEPTH)) && !deq_fire) |=> !enq_rdy);

  // R8: without a pop the head word stays put
  assert_head_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (deq_vld && !deq_fire) |=> (deq_vld && $stable(deq_data)));

endmodule

// File: rtl/busnet_rr_arb.sv
module busnet_rr_arb #(
  parameter int N  = 4,
  localparam int IW = busnet_pkg::idx_bits(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] win_idx
);

  logic [IW-1:0] ptr_q;
  logic          found;

  always_comb begin
    int pos;
    gnt     = '0;
    win_idx = '0;
    found   = 1'b0;
    for (int off = 0; off < N; off++) begin
      pos = busnet_pkg::ring_pos(int'(ptr_q), off, N);
      if (!found && req[IW'(pos)]) begin
        found             = 1'b1;
        gnt[IW'(pos)]     = 1'b1;
        win_idx           = IW'(pos);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (en && found) ptr_q <= IW'(busnet_pkg::wrap_inc(int'(win_idx), N));
  end

  // R4: never more than one grant
  assert_onehot_grant_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  // R5: any request gets some grant
  assert_grant_when_req_R5: assert property (@(posedge clk) disable iff (rst)
    (|req) |-> (|gnt));

  // R5: after a transfer the winner drops to lowest priority
  assert_rotate_R5: assert property (@(posedge clk) disable iff (rst)
    (en && found) |=> (ptr_q == IW'(busnet_pkg::wrap_inc(int'($past(win_idx)), N))));

  // R6: priority is held while no transfer completes
  assert_prio_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(ptr_q));

endmodule

// File: rtl/busnet_ctrl.sv
module busnet_ctrl #(
  parameter int N      = 4,
  parameter int DEST_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        gnt,
  input  logic [N*DEST_W-1:0] head_dest,
  input  logic [N-1:0]        out_ready,
  output logic [N-1:0]        out_valid,
  output logic                arb_en,
  output logic [N-1:0]        deq_rdy
);

  logic [DEST_W-1:0] sel_dest;
  logic              any_gnt;

  always_comb begin
    sel_dest = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt[i]) sel_dest = sel_dest | head_dest[i*DEST_W +: DEST_W];
    end
  end

  assign any_gnt = |gnt;

  always_comb begin
    for (int d = 0; d < N; d++) begin
      out_valid[d] = any_gnt && (sel_dest == DEST_W'(d));
    end
  end

  assign arb_en  = |(out_valid & out_ready);
  assign deq_rdy = arb_en ? gnt : '0;

  // R2: an output is valid exactly when some packet holds the bus
  assert_valid_tracks_grant_R2: assert property (@(posedge clk) disable iff (rst)
    ((|gnt) == (|out_valid)) && $onehot0(out_valid));

  // R6: a pop happens only for the granted input
  assert_pop_granted_R6: assert property (@(posedge clk) disable iff (rst)
    ((deq_rdy & ~gnt) == '0));

endmodule

// File: rtl/busnet_bus.sv
module busnet_bus #(
  parameter int N = 4,
  parameter int W = 16
) (
  input  logic [N-1:0]   gnt,
  input  logic [N*W-1:0] heads,
  output logic [W-1:0]   bus
);

  always_comb begin
    bus = '0;
    for (int i = 0; i < N; i++) begin
      bus = bus | (heads[i*W +: W] & {W{gnt[i]}});
    end
  end

endmodule

// File: rtl/shared_bus_net.sv
module shared_bus_net #(
  parameter int NTERM     = 4,
  parameter int PAYLOAD_W = 8,
  parameter int TAG_W     = 4,
  parameter int QDEPTH    = 2,
  localparam int DEST_W   = busnet_pkg::idx_bits(NTERM),
  localparam int PKT_W    = 2 * DEST_W + TAG_W + PAYLOAD_W,
  localparam int DEST_LSB = TAG_W + PAYLOAD_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NTERM-1:0]       in_valid,
  output logic [NTERM-1:0]       in_ready,
  input  logic [NTERM*PKT_W-1:0] in_pkt,
  output logic [NTERM-1:0]       out_valid,
  input  logic [NTERM-1:0]       out_ready,
  output logic [NTERM*PKT_W-1:0] out_pkt
);

  localparam int IW = busnet_pkg::idx_bits(NTERM);

  logic [NTERM-1:0]        head_vld;
  logic [NTERM-1:0]        deq_rdy;
  logic [NTERM*PKT_W-1:0]  head_pkt;
  logic [NTERM*DEST_W-1:0] head_dest;
  logic [NTERM-1:0]        gnt;
  logic [IW-1:0]           win_idx;
  logic                    arb_en;
  logic [PKT_W-1:0]        bus_word;
  logic                    bus_stall;

  for (genvar i = 0; i < NTERM; i++) begin : g_inq
    busnet_fifo #(.W(PKT_W), .DEPTH(QDEPTH)) u_q (
      .clk      (clk),
      .rst      (rst),
      .enq_vld  (in_valid[i]),
      .enq_rdy  (in_ready[i]),
      .enq_data (in_pkt[i*PKT_W +: PKT_W]),
      .deq_vld  (head_vld[i]),
      .deq_rdy  (deq_rdy[i]),
      .deq_data (head_pkt[i*PKT_W +: PKT_W])
    );
    assign head_dest[i*DEST_W +: DEST_W] = head_pkt[i*PKT_W + DEST_LSB +: DEST_W];
    assign out_pkt[i*PKT_W +: PKT_W]     = bus_word;
  end

  busnet_rr_arb #(.N(NTERM)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .en      (arb_en),
    .req     (head_vld),
    .gnt     (gnt),
    .win_idx (win_idx)
  );

  busnet_ctrl #(.N(NTERM), .DEST_W(DEST_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .gnt       (gnt),
    .head_dest (head_dest),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .arb_en    (arb_en),
    .deq_rdy   (deq_rdy)
  );

  busnet_bus #(.N(NTERM), .W(PKT_W)) u_bus (
    .gnt   (gnt),
    .heads (head_pkt),
    .bus   (bus_word)
  );

  assign bus_stall = (|out_valid) && !(|(out_valid & out_ready));

  // R10: an empty network drives no valid
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (head_vld == '0) |-> (out_valid == '0));

  // R6: a stalled packet is still waiting in its queue next cycle
  assert_stall_keeps_R6: assert property (@(posedge clk) disable iff (rst)
    bus_stall |=> (|(head_vld & $past(gnt))));

  // R4: the winning index names the single grant
  assert_win_matches_R4: assert property (@(posedge clk) disable iff (rst)
    (|gnt) |-> gnt[win_idx]);

endmodule

// File: tb/shared_bus_net_test.sv
module shared_bus_net_test;

  localparam int CLK_P = 10;
  localparam int N     = 4;
  localparam int PW    = 8;
  localparam int TW    = 4;
  localparam int PKT_W = 16;

  logic              clk = 1'b0;
  logic              rst;
  logic [N-1:0]      in_valid;
  logic [N-1:0]      in_ready;
  logic [N*PKT_W-1:0] in_pkt;
  logic [N-1:0]      out_valid;
  logic [N-1:0]      out_ready;
  logic [N*PKT_W-1:0] out_pkt;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  int mprio = 0;
  logic [PKT_W-1:0] qpkt [N][2];
  int rd [N];

  always #(CLK_P/2) clk = ~clk;

  shared_bus_net #(.NTERM(N), .PAYLOAD_W(PW), .TAG_W(TW), .QDEPTH(2)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_pkt(in_pkt), .out_valid(out_valid), .out_ready(out_ready), .out_pkt(out_pkt)
  );

  function automatic logic [PKT_W-1:0] mk_pkt(input int src, input int dst,
                                               input int tag, input int pay);
    return {2'(src), 2'(dst), 4'(tag), 8'(pay)};
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic int next_winner();
    for (int off = 0; off < N; off++) begin
      int p;
      p = (mprio + off) % N;
      if (rd[p] < 2) return p;
    end
    return -1;
  endfunction

  task automatic rr_burst(input int base);
    int w;
    out_ready = '0;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      in_valid = '1;
      for (int i = 0; i < N; i++) begin
        qpkt[i][k] = mk_pkt(i, (i + k + base) % N, (k*4 + i + base) & 15, i*16 + k + base*3);
        in_pkt[i*PKT_W +: PKT_W] = qpkt[i][k];
      end
      #1 chk("R7 room before fill", 32'(in_ready), 32'hf);
    end
    for (int i = 0; i < N; i++) rd[i] = 0;
    @(negedge clk);
    in_valid = '0;
    #1 chk("R7 full queues block input", 32'(in_ready), 32'h0);
    w = next_winner();
    chk("R6 stalled head shown", 32'(out_valid), 32'(1 << qpkt[w][0][13:12]));
    @(negedge clk);
    #1 chk("R6 stall holds packet", 32'(out_pkt[qpkt[w][0][13:12]*PKT_W +: PKT_W]), 32'(qpkt[w][0]));
    out_ready = '1;
    for (int s = 0; s < 2*N; s++) begin
      logic [PKT_W-1:0] e;
      w = next_winner();
      e = qpkt[w][rd[w]];
      chk("R5 grant order valid", 32'(out_valid), 32'(1 << e[13:12]));
      chk("R8 per-input order data", 32'(out_pkt[e[13:12]*PKT_W +: PKT_W]), 32'(e));
      rd[w]++;
      mprio = (w + 1) % N;
      @(negedge clk);
      #1;
    end
    chk("R10 drained network idle", 32'(out_valid), 32'h0);
    chk("R7 queues free again", 32'(in_ready), 32'hf);
  endtask

  initial begin
    int wd = 0;
    while (wd < 20000 && !done) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=done", wd);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    in_valid = '0;
    in_pkt = '0;
    out_ready = '1;
    repeat (3) @(negedge clk);
    #1 chk("R1 ready in reset", 32'(in_ready), 32'hf);
    chk("R1 no valid in reset", 32'(out_valid), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    #1 chk("R1 ready after reset", 32'(in_ready), 32'hf);
    chk("R1 idle after reset", 32'(out_valid), 32'h0);

    // R1 R5: first burst starts from input 0
    rr_burst(0);

    // R2 R3 R6 R9 R10: sweep every input and destination
    for (int s = 0; s < N; s++) begin
      for (int d = 0; d < N; d++) begin
        logic [PKT_W-1:0] p;
        p = mk_pkt((s + 1) % N, d, s*4 + d, 8'h5a ^ (s*16 + d));
        @(negedge clk);
        in_valid = '0;
        in_valid[s] = 1'b1;
        in_pkt[s*PKT_W +: PKT_W] = p;
        out_ready = ~(4'(1) << d);
        #1 chk("R3 empty queue accepts", 32'(in_ready[s]), 32'h1);
        @(negedge clk);
        in_valid = '0;
        #1 chk("R3 R2 one cycle to dest", 32'(out_valid), 32'(1 << d));
        chk("R9 packet unchanged", 32'(out_pkt[d*PKT_W +: PKT_W]), 32'(p));
        @(negedge clk);
        #1 chk("R6 blocked dest holds", 32'(out_valid), 32'(1 << d));
        out_ready = '1;
        @(negedge clk);
        #1 chk("R10 idle after delivery", 32'(out_valid), 32'h0);
        mprio = (s + 1) % N;
      end
    end

    // R5: second burst from the pointer left by the sweep
    rr_burst(1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule